// File: doc/BRIEF.md
# Interrupt enable and pending registers with supervisor delegation windows

This block holds the machine-level interrupt-enable and interrupt-pending vectors of a hart. It also presents the supervisor-level views of both vectors. A single read-modify-write access port reaches four selectable views. Each access carries a new value and a write mask and returns the value the view held before the access. The update takes effect at the next clock edge.

Software may set or clear only those pending bits that belong to supervisor interrupt sources and that hardware has not claimed. A claimed bit follows its hardware pending line on every cycle. The supervisor enable view is a window onto the machine enable vector, opened by the delegation mask. The supervisor pending view uses the machine pending logic, with its write mask first narrowed by the delegation mask. Choosing among pending interrupts and entering traps are left to neighbouring logic.

Top module: `irq_csr_window`

## Requirements
- R1: After reset, `enable_vec` and `pending_vec` are zero. `acc_rdata` is zero whenever `acc_valid` is low.
- R2: `acc_sel` = 0 selects the machine enable view. The stored vector becomes `(old & ~acc_wmask) | (acc_wdata & acc_wmask)`, limited to the six interrupt bits. `acc_rdata` returns the old value. Enable never changes on a cycle without an enable-view access.
- R3: `acc_sel` = 1 reads the supervisor enable view as `enable_vec & deleg_eff`. Here `deleg_eff` is `deleg` ANDed with the supervisor bits 1, 5 and 9.
- R4: A supervisor enable write merges mask and data into that view. It changes only the enable bits set in `deleg_eff`.
- R5: `acc_sel` = 2 writes pending bits through `acc_wmask & S & ~hw_claim`, where S holds bits 1, 5 and 9. Machine pending bits 3, 7 and 11 are never changed by software.
- R6: A pending access (`acc_sel` 2 or 3) returns the full pending vector as it was before the update, including machine bits.
- R7: `acc_sel` = 3 behaves like `acc_sel` = 2, except that its write mask is first ANDed with `deleg_eff`.
- R8: A pending bit whose `hw_claim` bit is set takes the value of `hw_pend` at every clock edge. A software write to that bit has no effect.
- R9: When the effective pending write mask is zero, the unclaimed pending bits keep their values and the current vector is returned.
- R10: Bits of `enable_vec` and `pending_vec` other than 1, 3, 5, 7, 9 and 11 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access strobe for this cycle |
| acc_sel | input | 2 | View: 0 machine enable, 1 supervisor enable, 2 machine pending, 3 supervisor pending |
| acc_wdata | input | XLEN | New value |
| acc_wmask | input | XLEN | Bits to be replaced |
| hw_pend | input | XLEN | Hardware pending lines |
| hw_claim | input | XLEN | Bits owned by hardware |
| deleg | input | XLEN | Interrupt delegation mask |
| acc_rdata | output | XLEN | Value of the selected view before the access |
| enable_vec | output | XLEN | Current enable vector |
| pending_vec | output | XLEN | Current pending vector |

## Verification
The bench uses the default XLEN of 32. This gives twenty bits above the interrupt layout. Writing all ones into those bits shows that none of them is ever stored. Driving `deleg` with bits outside the supervisor set shows that the delegation window is filtered before use. Claim masks move between supervisor and machine bits across the run. This exercises both ownership paths of the per-bit pending logic.

// File: rtl/irq_csr_pkg.sv
package irq_csr_pkg;

    typedef enum logic [1:0] {
        VIEW_M_ENABLE  = 2'd0,
        VIEW_S_ENABLE  = 2'd1,
        VIEW_M_PENDING = 2'd2,
        VIEW_S_PENDING = 2'd3
    } view_e;

    // Interrupt bit layout (neighbouring trap logic decodes these positions)
    localparam int unsigned BIT_S_SOFT  = 1;
    localparam int unsigned BIT_M_SOFT  = 3;
    localparam int unsigned BIT_S_TIMER = 5;
    localparam int unsigned BIT_M_TIMER = 7;
    localparam int unsigned BIT_S_EXT   = 9;
    localparam int unsigned BIT_M_EXT   = 11;
    localparam int unsigned LAYOUT_TOP  = 12;

endpackage

// File: rtl/irq_view_decode.sv
module irq_view_decode
    import irq_csr_pkg::*;
(
    input  logic       acc_valid,
    input  logic [1:0] acc_sel,
    output view_e      view,
    output logic       hit_m_en,
    output logic       hit_s_en,
    output logic       hit_pend,
    output logic       hit_s_pend
);
    always_comb begin
        view       = view_e'(acc_sel);
        hit_m_en   = 1'b0;
        hit_s_en   = 1'b0;
        hit_pend   = 1'b0;
        hit_s_pend = 1'b0;
        if (acc_valid) begin
            unique case (view)
                VIEW_M_ENABLE:  hit_m_en = 1'b1;
                VIEW_S_ENABLE:  hit_s_en = 1'b1;
                VIEW_M_PENDING: hit_pend = 1'b1;
                VIEW_S_PENDING: begin
                    hit_pend   = 1'b1;
                    hit_s_pend = 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/irq_enable_bank.sv
module irq_enable_bank #(
    parameter int unsigned XLEN = 32,
    parameter logic [XLEN-1:0] ALL_BITS = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_m,
    input  logic            wr_s,
    input  logic [XLEN-1:0] wdata,
    input  logic [XLEN-1:0] wmask,
    input  logic [XLEN-1:0] deleg_eff,
    output logic [XLEN-1:0] enable_q,
    output logic [XLEN-1:0] s_view
);
    logic [XLEN-1:0] old_view;
    logic [XLEN-1:0] merged;
    logic [XLEN-1:0] target;

    assign s_view = enable_q & deleg_eff;

    always_comb begin
        old_view = wr_s ? s_view : enable_q;
        merged   = (old_view & ~wmask) | (wdata & wmask);
        target   = wr_s ? ((enable_q & ~deleg_eff) | (merged & deleg_eff)) : merged;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_q <= '0;
        end else if (wr_m || wr_s) begin
            enable_q <= target & ALL_BITS;
        end
    end
endmodule

// File: rtl/irq_pending_bank.sv
module irq_pending_bank #(
    parameter int unsigned XLEN = 32,
    parameter logic [XLEN-1:0] ALL_BITS = '0,
    parameter logic [XLEN-1:0] SUP_BITS = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            acc,
    input  logic            sup,
    input  logic [XLEN-1:0] wdata,
    input  logic [XLEN-1:0] wmask,
    input  logic [XLEN-1:0] deleg_eff,
    input  logic [XLEN-1:0] hw_pend,
    input  logic [XLEN-1:0] hw_claim,
    output logic [XLEN-1:0] pending_q
);
    logic [XLEN-1:0] sw_mask;

    always_comb begin
        if (acc) begin
            sw_mask = wmask & (sup ? deleg_eff : {XLEN{1'b1}}) & SUP_BITS & ~hw_claim;
        end else begin
            sw_mask = '0;
        end
    end

    for (genvar i = 0; i < XLEN; i++) begin : g_bit
        if (ALL_BITS[i]) begin : g_live
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pending_q[i] <= 1'b0;
                end else if (hw_claim[i]) begin
                    pending_q[i] <= hw_pend[i];
                end else if (sw_mask[i]) begin
                    pending_q[i] <= wdata[i];
                end
            end
        end else begin : g_tied
            assign pending_q[i] = 1'b0;
        end
    end
endmodule

// File: rtl/irq_csr_window.sv
module irq_csr_window
    import irq_csr_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            acc_valid,
    input  logic [1:0]      acc_sel,
    input  logic [XLEN-1:0] acc_wdata,
    input  logic [XLEN-1:0] acc_wmask,
    input  logic [XLEN-1:0] hw_pend,
    input  logic [XLEN-1:0] hw_claim,
    input  logic [XLEN-1:0] deleg,
    output logic [XLEN-1:0] acc_rdata,
    output logic [XLEN-1:0] enable_vec,
    output logic [XLEN-1:0] pending_vec
);
    localparam logic [XLEN-1:0] ONE = {{(XLEN-1){1'b0}}, 1'b1};
    localparam logic [XLEN-1:0] SUP_BITS =
        (ONE << BIT_S_SOFT) | (ONE << BIT_S_TIMER) | (ONE << BIT_S_EXT);
    localparam logic [XLEN-1:0] MACH_BITS =
        (ONE << BIT_M_SOFT) | (ONE << BIT_M_TIMER) | (ONE << BIT_M_EXT);
    localparam logic [XLEN-1:0] ALL_BITS = SUP_BITS | MACH_BITS;

    view_e           view;
    logic            hit_m_en, hit_s_en, hit_pend, hit_s_pend;
    logic [XLEN-1:0] deleg_eff;
    logic [XLEN-1:0] s_view;

    assign deleg_eff = deleg & SUP_BITS;

    irq_view_decode u_decode (
        .acc_valid  (acc_valid),
        .acc_sel    (acc_sel),
        .view       (view),
        .hit_m_en   (hit_m_en),
        .hit_s_en   (hit_s_en),
        .hit_pend   (hit_pend),
        .hit_s_pend (hit_s_pend)
    );

    irq_enable_bank #(.XLEN(XLEN), .ALL_BITS(ALL_BITS)) u_enable (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_m      (hit_m_en),
        .wr_s      (hit_s_en),
        .wdata     (acc_wdata),
        .wmask     (acc_wmask),
        .deleg_eff (deleg_eff),
        .enable_q  (enable_vec),
        .s_view    (s_view)
    );

    irq_pending_bank #(.XLEN(XLEN), .ALL_BITS(ALL_BITS), .SUP_BITS(SUP_BITS)) u_pending (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc       (hit_pend),
        .sup       (hit_s_pend),
        .wdata     (acc_wdata),
        .wmask     (acc_wmask),
        .deleg_eff (deleg_eff),
        .hw_pend   (hw_pend),
        .hw_claim  (hw_claim),
        .pending_q (pending_vec)
    );

    // Read data: old contents of the selected view
    always_comb begin
        acc_rdata = '0;
        if (acc_valid) begin
            unique case (view)
                VIEW_M_ENABLE:  acc_rdata = enable_vec;
                VIEW_S_ENABLE:  acc_rdata = s_view;
                VIEW_M_PENDING,
                VIEW_S_PENDING: acc_rdata = pending_vec;
            endcase
        end
    end
endmodule

// File: rtl/irq_csr_window_chk.sv
module irq_csr_window_chk
    import irq_csr_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            acc_valid,
    input logic [1:0]      acc_sel,
    input logic [XLEN-1:0] deleg,
    input logic [XLEN-1:0] hw_pend,
    input logic [XLEN-1:0] hw_claim,
    input logic [XLEN-1:0] acc_rdata,
    input logic [XLEN-1:0] enable_vec,
    input logic [XLEN-1:0] pending_vec
);
    localparam logic [XLEN-1:0] ONE = {{(XLEN-1){1'b0}}, 1'b1};
    localparam logic [XLEN-1:0] SUP =
        (ONE << BIT_S_SOFT) | (ONE << BIT_S_TIMER) | (ONE << BIT_S_EXT);
    localparam logic [XLEN-1:0] MACH =
        (ONE << BIT_M_SOFT) | (ONE << BIT_M_TIMER) | (ONE << BIT_M_EXT);
    localparam logic [XLEN-1:0] ALL = SUP | MACH;

    p_idle_rdata_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> acc_rdata == '0);

    p_enable_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && !acc_sel[1]) |=> $stable(enable_vec));

    p_sview_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_sel == 2'd1) |=>
            ((enable_vec ^ $past(enable_vec)) & ~($past(deleg) & SUP)) == '0);

    p_mach_sw_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((pending_vec ^ $past(pending_vec)) & MACH & ~$past(hw_claim)) == '0);

    p_claim_track_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (pending_vec & $past(hw_claim) & ALL) == ($past(hw_pend) & $past(hw_claim) & ALL));

    p_pend_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && acc_sel[1]) |=> ((pending_vec ^ $past(pending_vec)) & ~$past(hw_claim)) == '0);

    p_layout_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((enable_vec | pending_vec) & ~ALL) == '0);
endmodule

bind irq_csr_window irq_csr_window_chk #(.XLEN(XLEN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid   (acc_valid),
    .acc_sel     (acc_sel),
    .deleg       (deleg),
    .hw_pend     (hw_pend),
    .hw_claim    (hw_claim),
    .acc_rdata   (acc_rdata),
    .enable_vec  (enable_vec),
    .pending_vec (pending_vec)
);

// File: tb/irq_csr_window_tb.sv
module irq_csr_window_tb;
    localparam int unsigned XLEN = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            acc_valid = 1'b0;
    logic [1:0]      acc_sel = '0;
    logic [XLEN-1:0] acc_wdata = '0;
    logic [XLEN-1:0] acc_wmask = '0;
    logic [XLEN-1:0] hw_pend = '0;
    logic [XLEN-1:0] hw_claim = '0;
    logic [XLEN-1:0] deleg = '0;
    logic [XLEN-1:0] acc_rdata;
    logic [XLEN-1:0] enable_vec;
    logic [XLEN-1:0] pending_vec;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_csr_window #(.XLEN(XLEN)) u_dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_sel(acc_sel),
        .acc_wdata(acc_wdata), .acc_wmask(acc_wmask), .hw_pend(hw_pend),
        .hw_claim(hw_claim), .deleg(deleg), .acc_rdata(acc_rdata),
        .enable_vec(enable_vec), .pending_vec(pending_vec)
    );

    task automatic check(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_acc(input logic [1:0] sel, input logic [XLEN-1:0] wd,
                          input logic [XLEN-1:0] wm, output logic [XLEN-1:0] rd);
        @(negedge clk);
        acc_valid = 1'b1; acc_sel = sel; acc_wdata = wd; acc_wmask = wm;
        #1 rd = acc_rdata;
        @(negedge clk);
        acc_valid = 1'b0; acc_wdata = '0; acc_wmask = '0;
        #1;
    endtask

    task automatic t_reset();
        check("R1 enable after reset", enable_vec, 32'h0);
        check("R1 pending after reset", pending_vec, 32'h0);
        check("R1 idle rdata", acc_rdata, 32'h0);
    endtask

    task automatic t_machine_enable();
        logic [XLEN-1:0] rd;
        do_acc(2'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, rd);
        check("R2 old enable returned", rd, 32'h0);
        check("R10 enable limited to six bits", enable_vec, 32'h0000_0AAA);
        do_acc(2'd0, 32'h0, 32'h0000_0008, rd);
        check("R2 old enable returned", rd, 32'h0000_0AAA);
        check("R2 masked clear of bit 3", enable_vec, 32'h0000_0AA2);
    endtask

    task automatic t_super_enable();
        logic [XLEN-1:0] rd;
        @(negedge clk); deleg = 32'hFFFF_FFFF;
        do_acc(2'd1, 32'h0, 32'h0, rd);
        check("R3 supervisor enable window", rd, 32'h0000_0222);
        check("R4 zero mask leaves enable", enable_vec, 32'h0000_0AA2);
        do_acc(2'd1, 32'h0, 32'hFFFF_FFFF, rd);
        check("R4 supervisor clear of delegated bits", enable_vec, 32'h0000_0880);
        @(negedge clk); deleg = 32'h0000_0020;
        do_acc(2'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, rd);
        check("R3 window read with narrow delegation", rd, 32'h0);
        check("R4 only delegated bit set", enable_vec, 32'h0000_08A0);
    endtask

    task automatic t_pending_claims();
        logic [XLEN-1:0] rd;
        do_acc(2'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, rd);
        check("R6 old pending returned", rd, 32'h0);
        check("R5 software sets supervisor bits only", pending_vec, 32'h0000_0222);
        @(negedge clk); hw_claim = 32'h0000_0020; hw_pend = 32'h0000_0020;
        do_acc(2'd2, 32'h0, 32'hFFFF_FFFF, rd);
        check("R6 old pending returned", rd, 32'h0000_0222);
        check("R8 claimed bit ignores software clear", pending_vec, 32'h0000_0020);
        @(negedge clk); hw_pend = 32'h0;
        @(negedge clk); #1;
        check("R8 claimed bit follows hardware", pending_vec, 32'h0);
        @(negedge clk); hw_claim = 32'h0000_0880; hw_pend = 32'h0000_0800;
        @(negedge clk); #1;
        check("R8 machine bit follows hardware", pending_vec, 32'h0000_0800);
        check("R2 enable untouched by pending traffic", enable_vec, 32'h0000_08A0);
    endtask

    task automatic t_zero_mask();
        logic [XLEN-1:0] rd;
        do_acc(2'd2, 32'hFFFF_FFFF, 32'h0, rd);
        check("R9 zero mask returns current", rd, 32'h0000_0800);
        check("R9 zero mask leaves pending", pending_vec, 32'h0000_0800);
        do_acc(2'd2, 32'hFFFF_FFFF, 32'h0000_0888, rd);
        check("R5 machine-only mask has no effect", pending_vec, 32'h0000_0800);
    endtask

    task automatic t_super_pending();
        logic [XLEN-1:0] rd;
        @(negedge clk); deleg = 32'h0000_0200;
        do_acc(2'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, rd);
        check("R6 supervisor view returns full pending", rd, 32'h0000_0800);
        check("R7 only delegated pending bit set", pending_vec, 32'h0000_0A00);
        @(negedge clk); deleg = 32'h0;
        do_acc(2'd3, 32'h0, 32'hFFFF_FFFF, rd);
        check("R6 supervisor view returns full pending", rd, 32'h0000_0A00);
        check("R7 no delegation blocks write", pending_vec, 32'h0000_0A00);
        check("R1 idle rdata", acc_rdata, 32'h0);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_machine_enable();
        t_super_enable();
        t_pending_claims();
        t_zero_mask();
        t_super_pending();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule